// File: doc/BRIEF.md
# UART Receive FIFO with Idle Timeout

This block is the receive-side byte queue of a UART. The deserializer pushes each received character into it, and a register-read path pops the oldest character. The queue holds a parameterized number of bytes (16 by default). A byte pushed while the queue is full is dropped, and that drop is reported as a one-cycle overrun pulse. A pair of controls, enable and disable, gates both sides: the queue is live only while enable is set and disable is clear. A read of an empty or inactive queue returns zero. A self-clearing software reset bit empties the queue.

Every accepted byte also restarts an inactivity timer that counts four character times. The character time is a register measured in clock cycles. It resets to the length of a ten-bit character at 9600 baud, derived from the clock-rate parameter, and a load strobe can replace it. When the timer runs out, the block emits a one-cycle timeout pulse, so software can collect a partial message that never reached a trigger level. Interrupt masking and merging, and the serial deserializer itself, are outside this block.

Top module: `uart_rxq`

## Requirements
- R1: After reset `count_o` is 0, `empty_o` is 1, and `full_o`, `overrun_o`, `timeout_o` and `rst_bit_o` are 0. The queue accepts up to DEPTH (default 16) bytes. `count_o` gives the number of stored bytes, and `full_o` is 1 exactly when that number equals DEPTH.
- R2: A push while the queue is active and full discards the byte and leaves the count and contents unchanged. `overrun_o` is then 1 for exactly the one cycle after that clock edge.
- R3: The queue is active only when `en_i`=1 and `dis_i`=0. While inactive, a push stores nothing and raises no overrun, and a pop removes nothing and reads 0 on `pop_data_o`.
- R4: A pop from an empty queue reads 0 on `pop_data_o` and leaves `count_o` at 0.
- R5: Bytes leave in the order they were accepted, including when the storage index wraps past DEPTH-1. `pop_data_o` presents the oldest byte combinationally, and a pop at a clock edge removes it.
- R6: A pulse on `sw_rst_wr_i` sets the reset bit, which shows on `rst_bit_o` in the following cycle. At the next edge the queue empties and the bit clears itself. Pushes and pops in that cycle have no effect.
- R7: Each accepted byte reloads the timer to L = 4 × character time. If no further byte is accepted, `timeout_o` goes high in the cycle that follows the L-th clock edge after the accepting edge. A byte accepted earlier restarts the count.
- R8: The timer stays idle from reset until the first accepted byte. Each reload produces at most one timeout pulse, one cycle wide.
- R9: The character time resets to (CLK_HZ/9600)×10 cycles. A `char_ld_i` pulse loads `char_cycles_i` (a value of 0 is taken as 1), and the new value takes effect at the next reload.
- R10: A push and a pop in the same cycle on an active queue that is neither empty nor full leave `count_o` unchanged. The oldest byte is removed and the new byte is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Receive enable control |
| dis_i | input | 1 | Receive disable control (overrides enable) |
| sw_rst_wr_i | input | 1 | Write pulse that sets the self-clearing reset bit |
| rst_bit_o | output | 1 | Software reset bit, pending for one cycle |
| push_i | input | 1 | Push strobe from the deserializer |
| push_data_i | input | DATA_W | Byte to push |
| pop_i | input | 1 | Pop strobe from the register read |
| pop_data_o | output | DATA_W | Oldest byte, or 0 when empty or inactive |
| count_o | output | $clog2(DEPTH)+1 | Stored byte count |
| empty_o | output | 1 | Count is zero |
| full_o | output | 1 | Count equals DEPTH |
| overrun_o | output | 1 | One-cycle pulse: byte dropped on a full queue |
| timeout_o | output | 1 | One-cycle pulse: inactivity timer expired |
| char_ld_i | input | 1 | Load strobe for the character time |
| char_cycles_i | input | CT_W | New character time in clock cycles |

## Verification
The bench targets the timer edges: it finds the exact cycle of the first timeout pulse at the reset-default and at a loaded character time, and counts the pulses. An off-by-one reload would move that cycle, a timer that is not rearmed would fire too early after a second byte, and one that stays armed would pulse again. It fills the queue from a non-zero write index so that the read index must wrap. A design that computed the read position wrongly would then return bytes out of order. It also pushes into a full queue, pushes and pops while inactive, pops when empty, and pushes and pops in the same cycle. A design that got these wrong would overwrite the oldest byte, miss or invent an overrun, leak stale data instead of zero, or drift the count.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_SWAP = 2'd3
   } rxq_op_e;

   function automatic rxq_op_e rxq_op(input logic do_push, input logic do_pop);
      rxq_op_e r;
      case ({do_pop, do_push})
         2'b01:   r = OP_PUSH;
         2'b10:   r = OP_POP;
         2'b11:   r = OP_SWAP;
         default: r = OP_NONE;
      endcase
      return r;
   endfunction

   function automatic bit rxq_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/uart_rxq_srst.sv
module uart_rxq_srst (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   output logic bit_o,
   output logic clr_o
);
   logic bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_q)  bit_q <= 1'b0;
      else if (wr_i)   bit_q <= 1'b1;
   end

   assign bit_o = bit_q;
   assign clr_o = bit_q;
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
   import uart_rxq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              active_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              accept_o,
   output logic              overrun_o
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_q;
   logic [PTR_W-1:0]  rd_ptr;
   logic [CNT_W-1:0]  cnt_q;
   logic              is_full, is_empty, take, ovr_d, ovr_q;
   rxq_op_e           op;

   assign is_full  = (cnt_q == FULL_CNT);
   assign is_empty = (cnt_q == '0);
   assign accept_o = active_i & push_i & ~is_full & ~clr_i;
   assign take     = active_i & pop_i & ~is_empty & ~clr_i;
   assign ovr_d    = active_i & push_i & is_full & ~clr_i;
   assign op       = rxq_op(accept_o, take);

   // oldest entry sits count places behind the write index (modulo depth)
   assign rd_ptr   = wr_q - cnt_q[PTR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         wr_q  <= '0;
         ovr_q <= 1'b0;
      end else begin
         ovr_q <= ovr_d;
         if (clr_i) begin
            cnt_q <= '0;
            wr_q  <= '0;
         end else begin
            if (accept_o) wr_q <= wr_q + 1'b1;
            case (op)
               OP_PUSH: cnt_q <= cnt_q + 1'b1;
               OP_POP:  cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < int'(DEPTH); e++) begin
         if (accept_o && (wr_q == PTR_W'(e))) mem_q[e] <= data_i;
      end
   end

   assign rdata_o   = (active_i && !is_empty) ? mem_q[rd_ptr] : '0;
   assign count_o   = cnt_q;
   assign overrun_o = ovr_q;
endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer
   import uart_rxq_pkg::*;
#(
   parameter int unsigned CT_W     = 24,
   parameter int unsigned TO_CHARS = 4,
   parameter int unsigned DEF_CT   = 52080,
   localparam int unsigned MUL_W   = $clog2(TO_CHARS + 1),
   localparam int unsigned LIM_W   = CT_W + MUL_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_i,
   input  logic [CT_W-1:0] ct_i,
   input  logic            kick_i,
   output logic            expire_o
);
   logic [CT_W-1:0]  ct_q;
   logic [LIM_W-1:0] lim;
   logic [LIM_W-1:0] cnt_q;
   logic             armed_q, exp_q, last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ct_q <= CT_W'(DEF_CT);
      else if (ld_i) ct_q <= (ct_i == '0) ? CT_W'(1) : ct_i;
   end

   generate
      if (rxq_is_pow2(TO_CHARS)) begin : g_shift
         assign lim = LIM_W'(ct_q) << $clog2(TO_CHARS);
      end else begin : g_mult
         assign lim = LIM_W'(ct_q) * LIM_W'(TO_CHARS);
      end
   endgenerate

   assign last = armed_q && (cnt_q <= LIM_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         exp_q   <= 1'b0;
      end else begin
         exp_q <= last && !kick_i;
         if (kick_i) begin
            cnt_q   <= lim;
            armed_q <= 1'b1;
         end else if (last) begin
            armed_q <= 1'b0;
         end else if (armed_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign expire_o = exp_q;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
   import uart_rxq_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned CT_W     = 24,
   parameter int unsigned TO_CHARS = 4,
   parameter int unsigned CLK_HZ   = 50_000_000,
   parameter int unsigned DEF_BAUD = 9600,
   parameter int unsigned DEF_BITS = 10,
   localparam int unsigned CNT_W   = $clog2(DEPTH) + 1,
   localparam int unsigned DEF_CT  = (CLK_HZ / DEF_BAUD) * DEF_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              dis_i,
   input  logic              sw_rst_wr_i,
   output logic              rst_bit_o,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              overrun_o,
   output logic              timeout_o,
   input  logic              char_ld_i,
   input  logic [CT_W-1:0]   char_cycles_i
);
   generate
      if (!rxq_is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("uart_rxq: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W == 0) begin : g_bad_width
         $error("uart_rxq: DATA_W must be non-zero");
      end
      if (TO_CHARS == 0) begin : g_bad_chars
         $error("uart_rxq: TO_CHARS must be non-zero");
      end
      if (DEF_CT == 0 || DEF_CT >= (64'd1 << CT_W)) begin : g_bad_ct
         $error("uart_rxq: default character time does not fit CT_W");
      end
   endgenerate

   logic active, clr, accept;

   assign active = en_i & ~dis_i;

   uart_rxq_srst u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (sw_rst_wr_i),
      .bit_o (rst_bit_o),
      .clr_o (clr)
   );

   uart_rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .active_i  (active),
      .push_i    (push_i),
      .data_i    (push_data_i),
      .pop_i     (pop_i),
      .rdata_o   (pop_data_o),
      .count_o   (count_o),
      .accept_o  (accept),
      .overrun_o (overrun_o)
   );

   uart_rxq_timer #(.CT_W(CT_W), .TO_CHARS(TO_CHARS), .DEF_CT(DEF_CT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (char_ld_i),
      .ct_i     (char_cycles_i),
      .kick_i   (accept),
      .expire_o (timeout_o)
   );

   assign empty_o = (count_o == '0);
   assign full_o  = (count_o == CNT_W'(DEPTH));
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned CT_W   = 24,
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic              dis_i,
   input logic              sw_rst_wr_i,
   input logic              rst_bit_o,
   input logic              push_i,
   input logic [DATA_W-1:0] push_data_i,
   input logic              pop_i,
   input logic [DATA_W-1:0] pop_data_o,
   input logic [CNT_W-1:0]  count_o,
   input logic              empty_o,
   input logic              full_o,
   input logic              overrun_o,
   input logic              timeout_o,
   input logic              char_ld_i,
   input logic [CT_W-1:0]   char_cycles_i
);
   localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

   // R1: count never exceeds the depth
   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= FULLC);

   // R2: an overrun pulse follows a push onto a full active queue
   a_r2_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> ($past(count_o) == FULLC && $past(push_i)));

   // R3: inactive queue keeps its count
   a_r3_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(en_i && !dis_i) && !rst_bit_o) |=> (count_o == $past(count_o)));

   // R4: empty queue reads zero
   a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == '0) |-> (pop_data_o == '0));

   // R6: a pending reset bit empties the queue and clears itself
   a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rst_bit_o |=> (!rst_bit_o && count_o == '0));

   // R8: timeout is a single-cycle pulse
   a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

   // R7: no timeout right after an accepted byte
   a_r7_no_tmo_after_push: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && en_i && !dis_i && count_o != FULLC && !rst_bit_o) |=> !timeout_o);

   // R10: simultaneous push and pop keep the count
   a_r10_swap_count: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && en_i && !dis_i && !rst_bit_o &&
       count_o != '0 && count_o != FULLC) |=> $stable(count_o));

   // R1: full flag tracks count
   a_r1_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
      full_o == (count_o == FULLC));
endmodule

bind uart_rxq uart_rxq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CT_W(CT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en_i          (en_i),
   .dis_i         (dis_i),
   .sw_rst_wr_i   (sw_rst_wr_i),
   .rst_bit_o     (rst_bit_o),
   .push_i        (push_i),
   .push_data_i   (push_data_i),
   .pop_i         (pop_i),
   .pop_data_o    (pop_data_o),
   .count_o       (count_o),
   .empty_o       (empty_o),
   .full_o        (full_o),
   .overrun_o     (overrun_o),
   .timeout_o     (timeout_o),
   .char_ld_i     (char_ld_i),
   .char_cycles_i (char_cycles_i)
);

// File: tb/uart_rxq_tb_top.sv
module uart_rxq_tb_top;
   localparam int unsigned DW     = 8;
   localparam int unsigned DEP    = 16;
   localparam int unsigned CTW    = 24;
   localparam int unsigned CLKHZ  = 96000;
   localparam int          DEF_L  = 4 * (CLKHZ / 9600) * 10;  // 400

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           en_i = 1'b0, dis_i = 1'b0, sw_rst_wr_i = 1'b0;
   logic           push_i = 1'b0, pop_i = 1'b0, char_ld_i = 1'b0;
   logic [DW-1:0]  push_data_i = '0;
   logic [CTW-1:0] char_cycles_i = '0;
   logic           rst_bit_o, empty_o, full_o, overrun_o, timeout_o;
   logic [DW-1:0]  pop_data_o;
   logic [4:0]     count_o;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [DW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   uart_rxq #(.DATA_W(DW), .DEPTH(DEP), .CT_W(CTW), .CLK_HZ(CLKHZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .dis_i(dis_i),
      .sw_rst_wr_i(sw_rst_wr_i), .rst_bit_o(rst_bit_o),
      .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
      .pop_data_o(pop_data_o), .count_o(count_o), .empty_o(empty_o),
      .full_o(full_o), .overrun_o(overrun_o), .timeout_o(timeout_o),
      .char_ld_i(char_ld_i), .char_cycles_i(char_cycles_i)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit live();
      return en_i && !dis_i;
   endfunction

   // driver: pushes one byte, records the expected outcome in the scoreboard
   task automatic push_byte(input logic [DW-1:0] d, input string req);
      bit ovr_exp;
      @(negedge clk);
      push_i = 1'b1; push_data_i = d;
      ovr_exp = live() && exp_q.size() == DEP;
      if (live() && exp_q.size() < DEP) exp_q.push_back(d);
      @(negedge clk);
      push_i = 1'b0;
      chk(overrun_o == ovr_exp, req, "overrun after push", overrun_o, ovr_exp);
   endtask

   // monitor: pops one byte and compares with the scoreboard head
   task automatic pop_byte(input string req);
      logic [DW-1:0] e;
      @(negedge clk);
      pop_i = 1'b1;
      #1;
      e = (live() && exp_q.size() > 0) ? exp_q.pop_front() : '0;
      chk(pop_data_o == e, req, "pop data", pop_data_o, e);
      @(negedge clk);
      pop_i = 1'b0;
   endtask

   task automatic watch_tmo(input int win, output int first, output int highs);
      first = -1; highs = 0;
      for (int k = 1; k <= win; k++) begin
         @(negedge clk);
         if (timeout_o) begin
            highs++;
            if (first < 0) first = k;
         end
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int first, highs, idle_tmo;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(count_o == 0 && empty_o && !full_o, "R1", "reset count/flags", count_o, 0);
      chk(!overrun_o && !timeout_o && !rst_bit_o, "R1", "reset pulses", overrun_o, 0);

      // R8: idle timer without any byte
      watch_tmo(DEF_L + 50, first, idle_tmo);
      chk(idle_tmo == 0, "R8", "timeout before first byte", idle_tmo, 0);

      en_i = 1'b1;
      // R9 default char time, R7 timing
      push_byte(8'hA5, "R2");
      watch_tmo(DEF_L + 20, first, highs);
      chk(first == DEF_L, "R9", "default timeout cycle", first, DEF_L);
      chk(highs == 1, "R8", "pulses per rearm", highs, 1);

      // R9 load char time 5 -> L = 20; R7 restart
      @(negedge clk); char_ld_i = 1'b1; char_cycles_i = 24'd5;
      @(negedge clk); char_ld_i = 1'b0;
      push_byte(8'h3C, "R2");
      repeat (10) @(negedge clk);
      push_byte(8'hC3, "R2");
      watch_tmo(50, first, highs);
      chk(first == 20, "R7", "restarted timeout cycle", first, 20);
      chk(highs == 1, "R8", "pulses after restart", highs, 1);

      // R5 order, R4 empty pop
      chk(count_o == 3, "R1", "count after three", count_o, 3);
      repeat (3) pop_byte("R5");
      pop_byte("R4");
      chk(count_o == 0, "R4", "count after empty pop", count_o, 0);

      // R2 fill, overrun; R5 wrap (write index starts at 3)
      for (int i = 0; i < DEP; i++) push_byte(DW'(i * 17 + 3), "R2");
      chk(count_o == DEP && full_o, "R1", "full count", count_o, DEP);
      push_byte(8'hEE, "R2");
      chk(count_o == DEP, "R2", "count after dropped push", count_o, DEP);
      @(negedge clk);
      chk(!overrun_o, "R2", "overrun width", overrun_o, 0);

      // R3 inactive while full: no overrun, pop reads zero and removes nothing
      dis_i = 1'b1;
      push_byte(8'h11, "R3");
      pop_byte("R3");
      chk(count_o == DEP, "R3", "count while disabled", count_o, DEP);
      dis_i = 1'b0;
      for (int i = 0; i < DEP; i++) pop_byte("R5");
      chk(count_o == 0, "R5", "drained", count_o, 0);

      en_i = 1'b0;
      push_byte(8'h22, "R3");
      chk(count_o == 0, "R3", "count with enable low", count_o, 0);
      en_i = 1'b1;

      // R10 simultaneous push and pop
      push_byte(8'h01, "R10"); push_byte(8'h02, "R10"); push_byte(8'h03, "R10");
      @(negedge clk);
      push_i = 1'b1; push_data_i = 8'h04; pop_i = 1'b1;
      #1;
      chk(pop_data_o == exp_q[0], "R10", "swap data", pop_data_o, exp_q[0]);
      void'(exp_q.pop_front()); exp_q.push_back(8'h04);
      @(negedge clk);
      push_i = 1'b0; pop_i = 1'b0;
      chk(count_o == 3, "R10", "swap count", count_o, 3);

      // R6 software reset
      @(negedge clk); sw_rst_wr_i = 1'b1;
      @(negedge clk); sw_rst_wr_i = 1'b0;
      chk(rst_bit_o == 1'b1 && count_o == 3, "R6", "bit pending", rst_bit_o, 1);
      push_i = 1'b1; push_data_i = 8'h77;
      @(negedge clk);
      push_i = 1'b0;
      chk(rst_bit_o == 1'b0, "R6", "bit self-clear", rst_bit_o, 0);
      chk(count_o == 0, "R6", "count after reset", count_o, 0);
      exp_q.delete();
      pop_byte("R6");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule